// File: doc/BRIEF.md
# Register Write Command Engine

This block is a small command processor that replays a queue of register writes kept in memory. Software places packed 64-bit instructions in a buffer and programs the start address into the head pointer. It then writes the end address into the tail pointer, and that write starts the run. The engine fetches one instruction pair at a time through a simple request/response read port, decodes it, and drives a one-cycle register-write strobe carrying offset, data and byte enables. It never reads registers.

Two instruction kinds are understood. A direct write carries its own data, byte enables and offset. An indexed write names one auto-increment register offset and a count N. The N data words follow it, and a zero word pads the run to an 8-byte boundary when N is odd. A pair whose upper word is all zeros is skipped as a no-op, so the zero fill up to the 64-byte-aligned tail costs fetches but causes no writes. Busy stays high until the head pointer reaches the tail. An unrecognised opcode halts the run and raises a sticky error flag.

Top module: `regwr_cmd_engine`

## Requirements
- R1: After reset, enable, busy and error are 0, the head pointer is 0, and no fetch request or register write is issued until a run starts.
- R2: A pair whose upper word has opcode 0x01 in bits 31:24 causes exactly one write: offset from upper bits 19:0, byte enables from upper bits 23:20, data from the lower word.
- R3: A pair whose upper word has opcode 0x09 in bits 31:24 is indexed. The lower word is a count N, and the following N data words are written in address order to the offset in upper bits 19:0, each with byte enables 4'hF. When N is odd, the pad word is fetched but not written. N = 0 produces no write.
- R4: A pair whose upper word is all zeros produces no write, and execution continues at the next pair.
- R5: Any other upper word halts the run. It produces no write, sets the error flag, clears busy, and leaves the head on the failing pair. Writing the control register with bit 1 set clears the error flag.
- R6: Control register is selector 0, with bit 0 as enable. Head is selector 1, with address bits 2:0 ignored. Tail is selector 2, with address bits 5:0 ignored. A tail write while idle and enabled, to an address different from the head, sets busy from the next cycle.
- R7: Busy falls in the same cycle the last write of the queue appears. The head pointer then equals the tail pointer.
- R8: While busy, writes to head and tail are ignored, and the enable bit cannot be cleared.
- R9: A tail write while enable is 0 stores the pointer but starts no run.
- R10: Fetch requests are single-cycle, 8-byte aligned, one outstanding at a time, and step upward by 8 from the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 head, 2 tail, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| eng_enable | output | 1 | Enable bit of the control register |
| eng_busy | output | 1 | Run in progress |
| eng_error | output | 1 | Sticky bad-opcode flag |
| eng_head | output | AW | Current head pointer (byte address) |
| mem_req | output | 1 | Fetch request, one cycle |
| mem_addr | output | AW | Fetch byte address, 8-byte aligned |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 64 | Response: bits 31:0 first word, 63:32 second word |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |

## Verification
The assertions assume that memory returns exactly one response for each request, and never one without a request. They also assume that software programs the head below the tail, so the run ends by reaching the tail and not by wrapping around. The bench memory model answers every request once after a chosen latency of one to three cycles, and every queue it builds starts at a head address below its line-aligned tail. Writes to the pointers during a run come only from the deliberate ignore test.

// File: rtl/rwce_pkg.sv
package rwce_pkg;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  typedef enum logic [1:0] {K_NOP, K_DIRECT, K_INDEXED, K_BAD} cmd_kind_t;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_HI} exec_state_t;

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  be;
    logic [19:0] off;
  } cmd_word_t;

  function automatic cmd_kind_t classify(input logic [31:0] upper);
    cmd_word_t w;
    w = upper;
    if (upper == 32'd0)          return K_NOP;
    else if (w.op == OP_DIRECT)  return K_DIRECT;
    else if (w.op == OP_INDEXED) return K_INDEXED;
    else                         return K_BAD;
  endfunction

  function automatic logic [31:0] align_down(input logic [31:0] a, input int lsb);
    logic [31:0] m;
    m = (32'd1 << lsb) - 32'd1;
    return a & ~m;
  endfunction
endpackage

// File: rtl/rwce_decode.sv
module rwce_decode
  import rwce_pkg::*;
#(
  parameter int OFF_W = 20
) (
  input  logic [63:0]      pair,
  output cmd_kind_t        kind,
  output logic [31:0]      lo_word,
  output logic [31:0]      hi_word,
  output logic [OFF_W-1:0] off,
  output logic [3:0]       be
);
  cmd_word_t cw;
  always_comb begin
    lo_word = pair[31:0];
    hi_word = pair[63:32];
    cw      = pair[63:32];
    kind    = classify(pair[63:32]);
    off     = cw.off[OFF_W-1:0];
    be      = cw.be;
  end
endmodule

// File: rtl/rwce_regs.sv
module rwce_regs
  import rwce_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          head_inc,
  input  logic          fin,
  input  logic          err_evt,
  output logic          enable,
  output logic          busy,
  output logic          error,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          start
);
  localparam int SLOT_LSB = 3;
  localparam int LINE_LSB = 6;
  localparam logic [AW-1:0] STEP = AW'(1 << SLOT_LSB);

  logic [AW-1:0] head_wr, tail_wr;
  logic wr_ctrl, wr_head, wr_tail;

  always_comb begin
    head_wr = AW'(align_down(cfg_wdata, SLOT_LSB));
    tail_wr = AW'(align_down(cfg_wdata, LINE_LSB));
    wr_ctrl = cfg_we && cfg_sel == SEL_CTRL;
    wr_head = cfg_we && cfg_sel == SEL_HEAD && !busy;
    wr_tail = cfg_we && cfg_sel == SEL_TAIL && !busy;
    start   = wr_tail && enable && (tail_wr != head);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      busy   <= 1'b0;
      error  <= 1'b0;
      head   <= '0;
      tail   <= '0;
    end else begin
      if (wr_ctrl && !busy) enable <= cfg_wdata[0];
      if (err_evt)                     error <= 1'b1;
      else if (wr_ctrl && cfg_wdata[1]) error <= 1'b0;
      if (wr_head)       head <= head_wr;
      else if (head_inc) head <= head + STEP;
      if (wr_tail) tail <= tail_wr;
      if (start)               busy <= 1'b1;
      else if (fin || err_evt) busy <= 1'b0;
    end
  end

  a_r8_tail_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tail));
  a_r8_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> enable);
  a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (!busy && error));
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r7_done_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fin) |=> (head == tail));
endmodule

// File: rtl/rwce_exec.sv
module rwce_exec
  import rwce_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             start,
  input  logic [AW-1:0]    head,
  input  logic [AW-1:0]    tail,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             head_inc,
  output logic             fin,
  output logic             err_evt,
  output logic             wr_valid,
  output logic [OFF_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_be
);
  localparam logic [AW-1:0] STEP = AW'(8);

  exec_state_t      state, nxt_state;
  logic [CNT_W-1:0] remain, nxt_remain;
  logic [OFF_W-1:0] run_off;
  logic [31:0]      hi_q;
  logic             wr_from_run;

  cmd_kind_t        dec_kind;
  logic [31:0]      dec_lo, dec_hi;
  logic [OFF_W-1:0] dec_off;
  logic [3:0]       dec_be;

  logic             emit, emit_run, load_run, at_end;
  logic [OFF_W-1:0] e_addr;
  logic [31:0]      e_data;
  logic [3:0]       e_be;

  rwce_decode #(.OFF_W(OFF_W)) u_dec (
    .pair(mem_rdata), .kind(dec_kind), .lo_word(dec_lo),
    .hi_word(dec_hi), .off(dec_off), .be(dec_be)
  );

  assign mem_req  = (state == S_REQ);
  assign mem_addr = head;

  always_comb begin
    nxt_state  = state;
    nxt_remain = remain;
    head_inc   = 1'b0;
    fin        = 1'b0;
    err_evt    = 1'b0;
    emit       = 1'b0;
    emit_run   = 1'b0;
    load_run   = 1'b0;
    e_addr     = run_off;
    e_data     = dec_lo;
    e_be       = 4'hF;
    at_end     = (head + STEP) == tail;
    unique case (state)
      S_IDLE: if (start) begin
        nxt_state  = S_REQ;
        nxt_remain = '0;
      end
      S_REQ: nxt_state = S_WAIT;
      S_WAIT: if (mem_rvalid) begin
        if (remain == '0) begin
          unique case (dec_kind)
            K_NOP: begin
              head_inc = 1'b1;
              fin      = at_end;
            end
            K_DIRECT: begin
              head_inc = 1'b1;
              emit     = 1'b1;
              e_addr   = dec_off;
              e_be     = dec_be;
              fin      = at_end;
            end
            K_INDEXED: begin
              head_inc   = 1'b1;
              load_run   = 1'b1;
              nxt_remain = CNT_W'(dec_lo);
              fin        = at_end;
            end
            default: err_evt = 1'b1;
          endcase
          nxt_state = (fin || err_evt) ? S_IDLE : S_REQ;
        end else begin
          head_inc   = 1'b1;
          emit       = 1'b1;
          emit_run   = 1'b1;
          nxt_remain = remain - 1'b1;
          if (remain > CNT_W'(1)) begin
            nxt_state = S_HI;
          end else begin
            fin       = at_end;
            nxt_state = fin ? S_IDLE : S_REQ;
          end
        end
      end
      S_HI: begin
        emit       = 1'b1;
        emit_run   = 1'b1;
        e_data     = hi_q;
        nxt_remain = remain - 1'b1;
        fin        = (head == tail);
        nxt_state  = fin ? S_IDLE : S_REQ;
      end
      default: nxt_state = S_IDLE;
    endcase
    if (fin) nxt_remain = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      remain      <= '0;
      run_off     <= '0;
      hi_q        <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      wr_be       <= '0;
      wr_from_run <= 1'b0;
    end else begin
      state    <= nxt_state;
      remain   <= nxt_remain;
      wr_valid <= emit;
      if (load_run) run_off <= dec_off;
      if (state == S_WAIT && mem_rvalid) hi_q <= dec_hi;
      if (emit) begin
        wr_addr     <= e_addr;
        wr_data     <= e_data;
        wr_be       <= e_be;
        wr_from_run <= emit_run;
      end
    end
  end

  a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r3_full_be: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_from_run) |-> (wr_be == 4'hF));
  a_r5_no_write_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !wr_valid);
endmodule

// File: rtl/regwr_cmd_engine.sv
module regwr_cmd_engine
  import rwce_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             eng_enable,
  output logic             eng_busy,
  output logic             eng_error,
  output logic [AW-1:0]    eng_head,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             wr_valid,
  output logic [OFF_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_be
);
  logic          head_inc, fin, err_evt, start;
  logic [AW-1:0] tail;

  rwce_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .head_inc(head_inc), .fin(fin), .err_evt(err_evt),
    .enable(eng_enable), .busy(eng_busy), .error(eng_error),
    .head(eng_head), .tail(tail), .start(start)
  );

  rwce_exec #(.AW(AW), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .start(start),
    .head(eng_head), .tail(tail), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .head_inc(head_inc), .fin(fin), .err_evt(err_evt),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  a_r7_write_inside_run: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(eng_busy));
endmodule

// File: tb/regwr_cmd_engine_bench.sv
module regwr_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        eng_enable, eng_busy, eng_error;
  logic [31:0] eng_head;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = 64'd0;
  logic        wr_valid;
  logic [19:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;

  regwr_cmd_engine u_regwr_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .eng_enable(eng_enable), .eng_busy(eng_busy),
    .eng_error(eng_error), .eng_head(eng_head), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  always #10 clk = ~clk;

  typedef struct packed { logic [19:0] a; logic [31:0] d; logic [3:0] be; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] mem [0:255];
  int          checks = 0;
  int          fails  = 0;
  int          lat    = 1;
  logic [31:0] exp_fetch = 32'd0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory model: one response per request after lat cycles (R10 addresses checked)
  initial begin
    int pend = 0;
    int idx;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          idx = int'(exp_fetch[9:2]) - 2;
          mem_rvalid = 1'b1;
          mem_rdata  = {mem[idx+1], mem[idx]};
        end
      end
      if (mem_req) begin
        chk(mem_addr == exp_fetch, "R10 fetch address", mem_addr, exp_fetch);
        exp_fetch = exp_fetch + 32'd8;
        pend = lat;
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (wr_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R3/R4 unexpected write", {wr_addr, wr_data}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk({wr_addr, wr_data, wr_be} == e, "R2/R3 write content",
              {wr_addr, wr_data, wr_be}, e);
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_direct(inout int wa, input logic [19:0] off, input logic [31:0] d,
                            input logic [3:0] be, input bit expect_it);
    mem[wa] = d;
    mem[wa+1] = {8'h01, be, off};
    wa += 2;
    if (expect_it) exp_q.push_back({off, d, be});
  endtask

  task automatic put_indexed(inout int wa, input logic [19:0] off, input int n, input logic [31:0] base);
    mem[wa] = n;
    mem[wa+1] = {8'h09, 4'h0, off};
    wa += 2;
    for (int k = 0; k < n; k++) begin
      mem[wa] = base + 32'(k) * 32'h11;
      exp_q.push_back({off, base + 32'(k) * 32'h11, 4'hF});
      wa++;
    end
    if (n % 2 == 1) begin
      mem[wa] = 32'd0;
      wa++;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && eng_busy; i++) @(negedge clk);
  endtask

  task automatic start_run(input logic [31:0] h, input logic [31:0] t);
    exp_fetch = h & ~32'h7;
    cfg_write(2'd1, h);
    cfg_write(2'd2, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int wa;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!eng_enable && !eng_busy && !eng_error, "R1 status", {eng_enable, eng_busy, eng_error}, 0);
    chk(eng_head == 0, "R1 head", eng_head, 0);

    // R9 tail write while disabled: no run
    start_run(32'h100, 32'h140);
    chk(!eng_busy, "R9 no start when disabled", eng_busy, 0);
    repeat (5) @(negedge clk);
    chk(!eng_busy, "R9 still idle", eng_busy, 0);

    // R2 R3 R4 R6: mixed queue, unaligned pointer bits ignored
    cfg_write(2'd0, 32'h1);
    wa = 32'h100 >> 2;
    put_direct(wa, 20'h12345, 32'hCAFE0001, 4'h3, 1'b1);
    put_indexed(wa, 20'h00A80, 3, 32'hA000_0000);
    put_direct(wa, 20'h00044, 32'h5A5A5A5A, 4'hF, 1'b1);
    lat = 1;
    start_run(32'h103, 32'h17F);
    chk(eng_busy, "R6 busy after tail write", eng_busy, 1);
    wait_idle();
    chk(eng_head == 32'h140, "R7 head reaches tail", eng_head, 32'h140);
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    // R8: pointer and enable writes ignored while busy
    wa = 32'h200 >> 2;
    put_indexed(wa, 20'h00B00, 8, 32'hB000_0000);
    put_direct(wa, 20'h00777, 32'h0000BEEF, 4'h1, 1'b1);
    lat = 3;
    start_run(32'h200, 32'h240);
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h400);
    cfg_write(2'd0, 32'h0);
    chk(eng_busy, "R8 still busy", eng_busy, 1);
    wait_idle();
    chk(eng_head == 32'h240, "R8 head unaffected", eng_head, 32'h240);
    chk(eng_enable, "R8 enable kept", eng_enable, 1);
    chk(exp_q.size() == 0, "R8 writes complete", exp_q.size(), 0);

    // R3 count zero and even count; R4 trailing no-ops
    wa = 32'h280 >> 2;
    put_indexed(wa, 20'h00044, 0, 32'h0);
    put_indexed(wa, 20'h00048, 2, 32'hC000_0000);
    put_direct(wa, 20'h0004C, 32'h12345678, 4'h8, 1'b1);
    lat = 2;
    start_run(32'h280, 32'h2C0);
    wait_idle();
    chk(eng_head == 32'h2C0, "R4 nops consumed", eng_head, 32'h2C0);
    chk(exp_q.size() == 0, "R3 zero and even counts", exp_q.size(), 0);

    // R5 bad opcode halts
    wa = 32'h300 >> 2;
    put_direct(wa, 20'h00100, 32'h11110000, 4'hF, 1'b1);
    mem[wa] = 32'hDEAD; mem[wa+1] = 32'h05000010; wa += 2;
    put_direct(wa, 20'h00200, 32'h22220000, 4'hF, 1'b0);
    lat = 1;
    start_run(32'h300, 32'h340);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(eng_error, "R5 error set", eng_error, 1);
    chk(!eng_busy, "R5 busy cleared", eng_busy, 0);
    chk(eng_head == 32'h308, "R5 head on bad pair", eng_head, 32'h308);
    chk(exp_q.size() == 0, "R5 no write after bad", exp_q.size(), 0);
    cfg_write(2'd0, 32'h3);
    chk(!eng_error && eng_enable, "R5 error cleared", {eng_error, eng_enable}, 1);

    // restart past the bad pair
    exp_q.push_back({20'h00200, 32'h22220000, 4'hF});
    start_run(32'h310, 32'h340);
    wait_idle();
    chk(eng_head == 32'h340 && !eng_error, "R7 restart completes", eng_head, 32'h340);
    chk(exp_q.size() == 0, "R2 restart write", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule